// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Wake-Up Filter

This block receives asynchronous serial frames on a shared multidrop line. Each frame can carry one extra bit after the eight data bits. This bit marks the frame as an address (ID) frame when it is 1, or as a data frame when it is 0. A node that is not being addressed can sleep through other nodes' traffic. Software sets a wake-up enable, and the receiver then throws away every data frame. It does not transfer the data, check it for errors, or raise any flag or interrupt. When the next ID frame arrives, the receiver accepts it as a normal frame and clears the wake-up enable by itself. Software can then read the address and decide whether to stay awake.

The line is oversampled using a 16x baud tick that comes from the bus clock. The receiver has:

- a control side: mode bits, wake-up enable set and clear strobes, interrupt enables, and flag clear strobes;
- a status side: receive-full, framing error, overrun, the last received multiprocessor bit, and the receive and error interrupt lines.

Top module: `mpu_rx_filter`

## Requirements
- R1: A frame is 1 start bit (0), 8 data bits LSB first, then 1 multiprocessor bit when `mp_fmt`=1, then 1 stop bit. Each bit lasts 16 `tick16` pulses and is sampled near its middle. A low pulse on `rxd` shorter than half a bit is not taken as a start bit.
- R2: While `wake_en`=0, every completed frame is loaded into `rx_data` and sets `rx_full`, whatever its multiprocessor bit. With `mp_fmt`=1, `mpb` takes that frame's multiprocessor bit.
- R3: When `wake_en`=1, `async_mode`=1 and `mp_fmt`=1, a frame whose multiprocessor bit is 0 is dropped. It leaves `rx_data`, `rx_full`, `fer`, `ovr` and `mpb` unchanged and raises no interrupt.
- R4: Under the same conditions, a frame whose multiprocessor bit is 1 is accepted as in R2. It sets `mpb` to 1 and clears `wake_en` to 0.
- R5: When `async_mode`=0 or `mp_fmt`=0, `wake_en` filters nothing and is not cleared by frames. With `mp_fmt`=0 the frame has no multiprocessor bit, and `mpb` keeps its value.
- R6: An accepted frame whose stop bit samples as 0 sets `fer`. Its data is still loaded.
- R7: An accepted frame that completes while `rx_full`=1 sets `ovr`, and `rx_data` keeps its old value.
- R8: The strobes `clr_full`, `clr_fer` and `clr_ovr` clear their flags. A strobe on a flag that is already 0 has no effect. A flag being set in the same cycle wins over its clear.
- R9: `rx_irq` equals `rx_full` AND `rx_ie`. `er_irq` equals (`fer` OR `ovr`) AND `er_ie`.
- R10: Reset leaves all flags, `mpb` and `wake_en` at 0. The `wake_set` strobe sets `wake_en` and the `wake_clr` strobe clears it, with `wake_set` taking priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial line, idle high |
| tick16 | input | 1 | Oversampling tick, 16 per bit |
| async_mode | input | 1 | 1 selects asynchronous operation |
| mp_fmt | input | 1 | 1 adds the multiprocessor bit to the frame |
| wake_set | input | 1 | Software write of 1 to the wake-up enable |
| wake_clr | input | 1 | Software write of 0 to the wake-up enable |
| rx_ie | input | 1 | Receive interrupt enable |
| er_ie | input | 1 | Receive-error interrupt enable |
| clr_full | input | 1 | Clear strobe for rx_full |
| clr_fer | input | 1 | Clear strobe for fer |
| clr_ovr | input | 1 | Clear strobe for ovr |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Receive data register holds unread data |
| fer | output | 1 | Framing error flag |
| ovr | output | 1 | Overrun flag |
| mpb | output | 1 | Multiprocessor bit of the last accepted frame |
| wake_en | output | 1 | Wake-up enable state |
| rx_irq | output | 1 | Receive interrupt request |
| er_irq | output | 1 | Receive-error interrupt request |

## Verification
A vector table runs frames through every combination that matters to the filter: wake-up enable off and on, multiprocessor bit 0 and 1, multiprocessor format on and off, asynchronous mode on and off, and good and bad stop bits.

These combinations tell apart the behaviours that are easy to confuse:
- A dropped frame, where the data, flags and `mpb` stay frozen.
- An ID frame that wakes the node and clears the enable.
- A frame that passes only because the filter is bypassed, with the enable left set.

Directed tests then check these cases one at a time:
- a start glitch;
- an overrun that keeps the old data;
- clear strobes on flags that are already clear;
- interrupt gating;
- software control of the wake-up enable.

// File: rtl/mpf_pkg.sv
`timescale 1ns/1ps
package mpf_pkg;
  typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} rx_state_e;

  // index of the stop bit counted from the first data bit
  function automatic int unsigned stop_index(input int unsigned dw, input logic mp_on);
    return dw + (mp_on ? 32'd1 : 32'd0);
  endfunction

  // tick count at which the middle of a bit is reached
  function automatic int unsigned mid_tick(input int unsigned osr);
    return osr / 2 - 1;
  endfunction
endpackage

// File: rtl/mpf_sampler.sv
`timescale 1ns/1ps
module mpf_sampler
  import mpf_pkg::*;
#(
  parameter int unsigned OSR = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd,
  input  logic          tick,
  input  logic          mp_on,
  output logic          frame_done,
  output logic [DW-1:0] frame_data,
  output logic          frame_mpb,
  output logic          frame_stop_ok
);
  localparam int unsigned CW = $clog2(OSR);
  localparam int unsigned IW = $clog2(DW + 2);
  localparam logic [CW-1:0] MID  = CW'(mid_tick(OSR));
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [IW-1:0] DLIM = IW'(DW);

  rx_state_e      state;
  logic [CW-1:0]  tcnt;
  logic [IW-1:0]  bidx;
  logic [DW-1:0]  shreg;
  logic [IW-1:0]  stop_idx;

  assign stop_idx   = IW'(stop_index(DW, mp_on));
  assign frame_data = shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      tcnt          <= '0;
      bidx          <= '0;
      shreg         <= '0;
      frame_mpb     <= 1'b0;
      frame_stop_ok <= 1'b0;
      frame_done    <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (state)
        S_IDLE: if (tick && !rxd) begin
          state <= S_START;
          tcnt  <= '0;
        end
        S_START: if (tick) begin
          if (tcnt == MID) begin
            if (!rxd) begin
              state     <= S_BITS;
              tcnt      <= '0;
              bidx      <= '0;
              frame_mpb <= 1'b0;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_BITS: if (tick) begin
          if (tcnt == LAST) begin
            tcnt <= '0;
            if (bidx == stop_idx) begin
              frame_done    <= 1'b1;
              frame_stop_ok <= rxd;
              state         <= S_IDLE;
            end else begin
              if (bidx < DLIM) shreg <= {rxd, shreg[DW-1:1]};
              else             frame_mpb <= rxd;
              bidx <= bidx + 1'b1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: a completed frame is reported for exactly one cycle
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R1: a high line at a tick never starts a frame
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && tick && rxd) |=> state == S_IDLE);
endmodule

// File: rtl/mpf_flags.sv
`timescale 1ns/1ps
module mpf_flags #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_done,
  input  logic [DW-1:0] frame_data,
  input  logic          frame_mpb,
  input  logic          frame_stop_ok,
  input  logic          async_mode,
  input  logic          mp_fmt,
  input  logic          wake_set,
  input  logic          wake_clr,
  input  logic          clr_full,
  input  logic          clr_fer,
  input  logic          clr_ovr,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          fer,
  output logic          ovr,
  output logic          mpb,
  output logic          wake_en,
  output logic          frame_take,
  output logic          frame_drop
);
  logic filter_on, id_hit;

  assign filter_on  = async_mode & mp_fmt & wake_en;
  assign frame_drop = frame_done & filter_on & ~frame_mpb;
  assign frame_take = frame_done & ~frame_drop;
  assign id_hit     = frame_done & filter_on & frame_mpb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      fer     <= 1'b0;
      ovr     <= 1'b0;
      mpb     <= 1'b0;
      wake_en <= 1'b0;
    end else begin
      if (frame_take && !rx_full) rx_data <= frame_data;
      rx_full <= (rx_full & ~clr_full) | frame_take;
      ovr     <= (ovr & ~clr_ovr) | (frame_take & rx_full);
      fer     <= (fer & ~clr_fer) | (frame_take & ~frame_stop_ok);
      if (frame_take && mp_fmt) mpb <= frame_mpb;
      if (wake_set)                 wake_en <= 1'b1;
      else if (wake_clr || id_hit)  wake_en <= 1'b0;
    end
  end

  // R3: a dropped frame touches no status
  p_drop_freezes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_drop && !clr_full && !clr_fer && !clr_ovr) |=>
      ($stable(rx_data) && $stable(rx_full) && $stable(fer) && $stable(ovr) && $stable(mpb)));
  // R4: an ID frame while filtering wakes the node
  p_id_wakes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && async_mode && mp_fmt && wake_en && frame_mpb && !wake_set) |=>
      (!wake_en && mpb && rx_full));
  // R5: without multiprocessor format every frame lands
  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !mp_fmt) |=> rx_full);
  // R7: overrun keeps the held byte
  p_ovr_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_take && rx_full) |=> (ovr && $stable(rx_data)));
endmodule

// File: rtl/mpu_rx_filter.sv
`timescale 1ns/1ps
module mpu_rx_filter #(
  parameter int unsigned OSR = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd,
  input  logic          tick16,
  input  logic          async_mode,
  input  logic          mp_fmt,
  input  logic          wake_set,
  input  logic          wake_clr,
  input  logic          rx_ie,
  input  logic          er_ie,
  input  logic          clr_full,
  input  logic          clr_fer,
  input  logic          clr_ovr,
  output logic [DW-1:0] rx_data,
  output logic          rx_full,
  output logic          fer,
  output logic          ovr,
  output logic          mpb,
  output logic          wake_en,
  output logic          rx_irq,
  output logic          er_irq
);
  logic          frame_done, frame_mpb, frame_stop_ok;
  logic [DW-1:0] frame_data;
  logic          frame_take, frame_drop;

  mpf_sampler #(.OSR(OSR), .DW(DW)) u_smp (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick16), .mp_on(mp_fmt),
    .frame_done(frame_done), .frame_data(frame_data),
    .frame_mpb(frame_mpb), .frame_stop_ok(frame_stop_ok)
  );

  mpf_flags #(.DW(DW)) u_flg (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_data(frame_data),
    .frame_mpb(frame_mpb), .frame_stop_ok(frame_stop_ok),
    .async_mode(async_mode), .mp_fmt(mp_fmt),
    .wake_set(wake_set), .wake_clr(wake_clr),
    .clr_full(clr_full), .clr_fer(clr_fer), .clr_ovr(clr_ovr),
    .rx_data(rx_data), .rx_full(rx_full), .fer(fer), .ovr(ovr), .mpb(mpb),
    .wake_en(wake_en), .frame_take(frame_take), .frame_drop(frame_drop)
  );

  assign rx_irq = rx_full & rx_ie;
  assign er_irq = (fer | ovr) & er_ie;

  // R3: no interrupt can come from a dropped frame
  p_drop_no_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_drop && !rx_full && !fer && !ovr && !clr_full) |=> (!rx_irq && !er_irq));
endmodule

// File: tb/mpu_rx_filter_test.sv
`timescale 1ns/1ps
module mpu_rx_filter_test;
  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, tick16 = 1'b0;
  logic async_mode = 1'b1, mp_fmt = 1'b1, wake_set = 1'b0, wake_clr = 1'b0;
  logic rx_ie = 1'b1, er_ie = 1'b1, clr_full = 1'b0, clr_fer = 1'b0, clr_ovr = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, fer, ovr, mpb, wake_en, rx_irq, er_irq;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  mpu_rx_filter uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16), .async_mode(async_mode),
    .mp_fmt(mp_fmt), .wake_set(wake_set), .wake_clr(wake_clr), .rx_ie(rx_ie),
    .er_ie(er_ie), .clr_full(clr_full), .clr_fer(clr_fer), .clr_ovr(clr_ovr),
    .rx_data(rx_data), .rx_full(rx_full), .fer(fer), .ovr(ovr), .mpb(mpb),
    .wake_en(wake_en), .rx_irq(rx_irq), .er_irq(er_irq)
  );

  always #2.5 clk = ~clk;
  initial forever begin @(negedge clk); tick16 = ~tick16; end

  localparam int BIT_CYC = 32;  // 16 ticks, one tick every 2 cycles

  typedef struct packed {
    logic asy; logic mp; logic wk; logic [7:0] d; logic mb; logic stp;
    logic take; logic wake_after;
  } vec_t;

  localparam vec_t VT [0:7] = '{
    '{1'b1, 1'b1, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b0},  // R2 data frame, no filter
    '{1'b1, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b0},  // R2 ID frame, no filter
    '{1'b1, 1'b1, 1'b1, 8'h55, 1'b0, 1'b1, 1'b0, 1'b1},  // R3 dropped
    '{1'b1, 1'b1, 1'b1, 8'h81, 1'b1, 1'b1, 1'b1, 1'b0},  // R4 wake-up
    '{1'b1, 1'b0, 1'b1, 8'hC3, 1'b0, 1'b1, 1'b1, 1'b1},  // R5 no mp format
    '{1'b0, 1'b1, 1'b1, 8'h7E, 1'b0, 1'b1, 1'b1, 1'b1},  // R5 not async
    '{1'b1, 1'b1, 1'b0, 8'h0F, 1'b0, 1'b0, 1'b1, 1'b0},  // R6 bad stop
    '{1'b1, 1'b1, 1'b1, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b1}   // R3 bad stop dropped
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (BIT_CYC) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic with_mp, input logic mb, input logic stp);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (with_mp) send_bit(mb);
    send_bit(stp);
    rxd = 1'b1;
    repeat (BIT_CYC) @(negedge clk);
  endtask

  task automatic pulse_clear();
    clr_full = 1'b1; clr_fer = 1'b1; clr_ovr = 1'b1;
    @(negedge clk);
    clr_full = 1'b0; clr_fer = 1'b0; clr_ovr = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_wake(input logic v);
    if (v) wake_set = 1'b1; else wake_clr = 1'b1;
    @(negedge clk);
    wake_set = 1'b0; wake_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] m_data;
    logic m_mpb;
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10", "rx_full", rx_full, 0);
    check("R10", "fer", fer, 0);
    check("R10", "ovr", ovr, 0);
    check("R10", "mpb", mpb, 0);
    check("R10", "wake_en", wake_en, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    m_data = 8'h00; m_mpb = 1'b0;
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VT[i];
      pulse_clear();
      pulse_wake(1'b0);
      async_mode = v.asy; mp_fmt = v.mp;
      if (v.wk) pulse_wake(1'b1);
      send_frame(v.d, v.mp, v.mb, v.stp);
      if (v.take) begin
        m_data = v.d;
        if (v.mp) m_mpb = v.mb;
      end
      check("R2-R6 row", $sformatf("rx_data row%0d", i), rx_data, m_data);
      check("R2-R6 row", $sformatf("rx_full row%0d", i), rx_full, v.take);
      check("R6", $sformatf("fer row%0d", i), fer, v.take & ~v.stp);
      check("R4", $sformatf("mpb row%0d", i), mpb, m_mpb);
      check("R4", $sformatf("wake_en row%0d", i), wake_en, v.wake_after);
      check("R9", $sformatf("rx_irq row%0d", i), rx_irq, v.take);
      check("R9", $sformatf("er_irq row%0d", i), er_irq, v.take & ~v.stp);
    end

    // R1 start glitch ignored
    async_mode = 1'b1; mp_fmt = 1'b1;
    pulse_clear(); pulse_wake(1'b0);
    rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (20 * BIT_CYC) @(negedge clk);
    check("R1", "glitch rx_full", rx_full, 0);
    check("R1", "glitch rx_data", rx_data, m_data);

    // R7 overrun keeps old data
    send_frame(8'h12, 1'b1, 1'b0, 1'b1);
    check("R1", "lsb-first data", rx_data, 8'h12);
    send_frame(8'h34, 1'b1, 1'b0, 1'b1);
    check("R7", "ovr", ovr, 1);
    check("R7", "rx_data kept", rx_data, 8'h12);
    check("R9", "er_irq on ovr", er_irq, 1);

    // R9 gating
    rx_ie = 1'b0; er_ie = 1'b0;
    @(negedge clk);
    check("R9", "rx_irq masked", rx_irq, 0);
    check("R9", "er_irq masked", er_irq, 0);
    rx_ie = 1'b1; er_ie = 1'b1;

    // R8 clearing
    clr_fer = 1'b1; @(negedge clk); clr_fer = 1'b0; @(negedge clk);
    check("R8", "fer clear on 0 no effect", fer, 0);
    check("R8", "ovr untouched", ovr, 1);
    check("R8", "rx_full untouched", rx_full, 1);
    clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0; @(negedge clk);
    check("R8", "ovr cleared", ovr, 0);
    clr_full = 1'b1; @(negedge clk); clr_full = 1'b0; @(negedge clk);
    check("R8", "rx_full cleared", rx_full, 0);
    check("R8", "rx_data after clear", rx_data, 8'h12);

    // R10 software control of wake enable
    pulse_wake(1'b1);
    check("R10", "wake_set", wake_en, 1);
    wake_set = 1'b1; wake_clr = 1'b1; @(negedge clk);
    wake_set = 1'b0; wake_clr = 1'b0; @(negedge clk);
    check("R10", "set wins", wake_en, 1);
    pulse_wake(1'b0);
    check("R10", "wake_clr", wake_en, 0);

    finish_run();
  end
endmodule